// File: doc/BRIEF.md
# Machine Trap Vector Register with Redirect Generation

This block holds the machine-mode trap vector for a 64-bit core and builds the program-counter redirect used when a trap is taken. Software writes the register through a CSR write port and reads it back through a CSR read port. When the pipeline raises a trap request, the block registers a redirect target one cycle later. The target is derived from the same stored value that a CSR read returns.

The register is write-any, read-legal. Address bits that the core does not implement are removed when the register is written. A read therefore always shows the exact base that a later trap will use, and a trap can never jump to a low alias of a value that software saw. The two low bits select the mode. Direct mode sends every trap to the base. Vectored mode offsets asynchronous interrupts by four bytes per cause number.

A small range check follows the redirect target. In vectored mode, adding the offset can carry past the implemented physical range. When that happens the check flags the target so that an instruction access fault can be raised at that address.

Top module: `tvec_redirect_unit`

## Requirements
- R1: After reset, `csr_rd_data` equals the reset vector (default 0x0000_0000_8000_0000) with mode direct (bits [1:0] = 0), and `redirect_valid` and `redirect_fault` are 0.
- R2: A CSR write clears every bit at or above PADDR_BITS (default 39). The legalized value is visible on `csr_rd_data` from the cycle after the write. For example, a write of 0x2000_0000_8000_005C reads back as 0x0000_0000_8000_005C.
- R3: Bits [1:0] are the mode: 0 = direct, 1 = vectored. A write whose bits [1:0] are 2 or 3 keeps the previous mode and still updates the base bits [63:2].
- R4: In direct mode, the cycle after `trap_valid`, `redirect_pc` equals the stored value with bits [1:0] forced to 0. This holds for any cause and for both interrupts and exceptions.
- R5: In vectored mode, an interrupt (`trap_is_intr` = 1) with cause n redirects to base + 4*n. An exception redirects to the base.
- R6: When a write and a trap arrive in the same cycle, the trap uses the value held before that cycle and the write is discarded.
- R7: When `redirect_pc` has any bit set at or above PADDR_BITS, `redirect_fault` is 1 and `fault_cause` is 1 (instruction access fault). Otherwise both are 0.
- R8: For any written value, a direct-mode trap taken afterwards redirects to `csr_rd_data` with bits [1:0] cleared.
- R9: `redirect_valid` is high for exactly the one cycle after each cycle in which `trap_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr_en | input | 1 | CSR write strobe |
| csr_wr_data | input | 64 | Value to write |
| csr_rd_data | output | 64 | Held (legalized) register value |
| trap_valid | input | 1 | Trap taken this cycle |
| trap_is_intr | input | 1 | 1 = asynchronous interrupt, 0 = synchronous exception |
| trap_cause | input | 6 | Cause number of the trap |
| redirect_valid | output | 1 | Redirect target valid (one cycle) |
| redirect_pc | output | 64 | Redirect target address |
| redirect_fault | output | 1 | Target lies outside the implemented range |
| fault_cause | output | 4 | Fault cause code, 1 when `redirect_fault` is set |

## Verification
The vector table pairs each written value with a trap. The values include:
- a value with high tag bits set and mode 0;
- vectored values with interrupts and with exceptions;
- mode codes 2 and 3 arriving after a vectored setting;
- base values near the top of the implemented range, where the vectored offset carries out of the range and must raise the fault.

These patterns separate high-bit legalization, mode retention and offset arithmetic, and they show whether the fault comes only from a true carry. Directed cases cover the reset vector and a write that arrives together with a trap, which shows whether the old value or the new one is used. A run of random writes checks that readback and redirect base always agree.

// File: rtl/tvec_pkg.sv
package tvec_pkg;
   typedef enum logic [1:0] {
      TV_DIRECT   = 2'd0,
      TV_VECTORED = 2'd1
   } tvec_mode_e;

   localparam logic [3:0] IACC_FAULT_CODE = 4'd1;
   localparam logic [3:0] NO_FAULT_CODE   = 4'd0;
endpackage

// File: rtl/tvec_legalizer.sv
module tvec_legalizer #(
   parameter int unsigned XLEN        = 64,
   parameter int unsigned PADDR_BITS  = 39,
   parameter bit          VECTORED_EN = 1'b1
) (
   input  logic [XLEN-1:0] wr_value,
   input  logic [1:0]      cur_mode,
   output logic [XLEN-1:0] legal_value
);
   import tvec_pkg::*;

   logic [XLEN-1:0] base_part;
   logic [1:0]      mode_part;

   generate
      if (PADDR_BITS < XLEN) begin : g_trim
         assign base_part = {{(XLEN-PADDR_BITS){1'b0}}, wr_value[PADDR_BITS-1:2], 2'b00};
      end else begin : g_full
         assign base_part = {wr_value[XLEN-1:2], 2'b00};
      end

      if (VECTORED_EN) begin : g_vec
         always_comb begin
            if (wr_value[1:0] == TV_DIRECT || wr_value[1:0] == TV_VECTORED)
               mode_part = wr_value[1:0];
            else
               mode_part = cur_mode;
         end
      end else begin : g_dir_only
         assign mode_part = TV_DIRECT;
      end
   endgenerate

   assign legal_value = base_part | {{(XLEN-2){1'b0}}, mode_part};
endmodule

// File: rtl/tvec_target_gen.sv
module tvec_target_gen #(
   parameter int unsigned XLEN       = 64,
   parameter int unsigned CAUSE_BITS = 6
) (
   input  logic [XLEN-1:0]       held_value,
   input  logic                  is_intr,
   input  logic [CAUSE_BITS-1:0] cause,
   output logic [XLEN-1:0]       target
);
   import tvec_pkg::*;

   logic [XLEN-1:0] base_addr;
   logic [XLEN-1:0] offset;
   logic            use_offset;

   assign base_addr  = {held_value[XLEN-1:2], 2'b00};
   assign use_offset = is_intr && (held_value[1:0] == TV_VECTORED);
   assign offset     = use_offset ? (XLEN'(cause) << 2) : '0;
   assign target     = base_addr + offset;
endmodule

// File: rtl/fetch_range_chk.sv
module fetch_range_chk #(
   parameter int unsigned XLEN       = 64,
   parameter int unsigned PADDR_BITS = 39
) (
   input  logic [XLEN-1:0] addr,
   output logic            out_of_range
);
   generate
      if (PADDR_BITS < XLEN) begin : g_chk
         assign out_of_range = |addr[XLEN-1:PADDR_BITS];
      end else begin : g_none
         assign out_of_range = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/tvec_redirect_unit.sv
module tvec_redirect_unit #(
   parameter int unsigned XLEN        = 64,
   parameter int unsigned PADDR_BITS  = 39,
   parameter int unsigned CAUSE_BITS  = 6,
   parameter bit          VECTORED_EN = 1'b1,
   parameter logic [63:0] RESET_VEC   = 64'h0000_0000_8000_0000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  csr_wr_en,
   input  logic [XLEN-1:0]       csr_wr_data,
   output logic [XLEN-1:0]       csr_rd_data,
   input  logic                  trap_valid,
   input  logic                  trap_is_intr,
   input  logic [CAUSE_BITS-1:0] trap_cause,
   output logic                  redirect_valid,
   output logic [XLEN-1:0]       redirect_pc,
   output logic                  redirect_fault,
   output logic [3:0]            fault_cause
);
   import tvec_pkg::*;

   localparam logic [XLEN-1:0] RESET_VALUE = XLEN'(RESET_VEC);

   generate
      if (XLEN < 8 || XLEN > 64) begin : g_bad_xlen
         $error("tvec_redirect_unit: XLEN out of supported range");
      end
      if (PADDR_BITS < 3 || PADDR_BITS > XLEN) begin : g_bad_paddr
         $error("tvec_redirect_unit: PADDR_BITS must lie in 3..XLEN");
      end
      if (RESET_VEC[1:0] != 2'b00 || (RESET_VEC >> PADDR_BITS) != 64'd0) begin : g_bad_rst
         $error("tvec_redirect_unit: RESET_VEC must be aligned and inside the address range");
      end
   endgenerate

   logic [XLEN-1:0] held_q;
   logic [XLEN-1:0] legal_value;
   logic [XLEN-1:0] target;
   logic            pc_out_of_range;
   logic            rv_q;
   logic [XLEN-1:0] rpc_q;

   tvec_legalizer #(
      .XLEN(XLEN), .PADDR_BITS(PADDR_BITS), .VECTORED_EN(VECTORED_EN)
   ) u_legal (
      .wr_value(csr_wr_data), .cur_mode(held_q[1:0]), .legal_value(legal_value)
   );

   tvec_target_gen #(
      .XLEN(XLEN), .CAUSE_BITS(CAUSE_BITS)
   ) u_target (
      .held_value(held_q), .is_intr(trap_is_intr), .cause(trap_cause), .target(target)
   );

   fetch_range_chk #(
      .XLEN(XLEN), .PADDR_BITS(PADDR_BITS)
   ) u_range (
      .addr(rpc_q), .out_of_range(pc_out_of_range)
   );

   // Trap wins over a same-cycle write: the write is dropped.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held_q <= RESET_VALUE;
      else if (csr_wr_en && !trap_valid)
         held_q <= legal_value;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rv_q  <= 1'b0;
         rpc_q <= '0;
      end else begin
         rv_q <= trap_valid;
         if (trap_valid)
            rpc_q <= target;
      end
   end

   assign csr_rd_data    = held_q;
   assign redirect_valid = rv_q;
   assign redirect_pc    = rpc_q;
   assign redirect_fault = rv_q && pc_out_of_range;
   assign fault_cause    = redirect_fault ? IACC_FAULT_CODE : NO_FAULT_CODE;

   generate
      if (PADDR_BITS < XLEN) begin : g_a_upper
         a_r2_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
            csr_rd_data[XLEN-1:PADDR_BITS] == '0);
      end
   endgenerate

   a_r3_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
      csr_rd_data[1] == 1'b0);

   a_r6_trap_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |=> $stable(csr_rd_data));

   a_r9_pulse_on: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |=> redirect_valid);

   a_r9_pulse_off: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_valid |=> !redirect_valid);

   a_r4_direct_base: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && csr_rd_data[1:0] == TV_DIRECT) |=>
         redirect_pc == {$past(csr_rd_data[XLEN-1:2]), 2'b00});

   a_r7_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_fault |-> (redirect_valid && fault_cause == IACC_FAULT_CODE));
endmodule

// File: tb/tb_tvec_redirect_unit.sv
module tb_tvec_redirect_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_wr_en = 1'b0;
   logic [63:0] csr_wr_data = '0;
   logic [63:0] csr_rd_data;
   logic        trap_valid = 1'b0;
   logic        trap_is_intr = 1'b0;
   logic [5:0]  trap_cause = '0;
   logic        redirect_valid;
   logic [63:0] redirect_pc;
   logic        redirect_fault;
   logic [3:0]  fault_cause;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   tvec_redirect_unit dut (
      .clk(clk), .rst_n(rst_n),
      .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data), .csr_rd_data(csr_rd_data),
      .trap_valid(trap_valid), .trap_is_intr(trap_is_intr), .trap_cause(trap_cause),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
      .redirect_fault(redirect_fault), .fault_cause(fault_cause)
   );

   localparam int NV = 8;
   localparam logic [63:0] V_WR [NV] = '{
      64'h2000_0000_8000_005C, 64'h0000_0000_8000_1001, 64'h0000_0000_8000_2001,
      64'hFFFF_FFFF_FFFF_FFFE, 64'h0000_0040_0000_0003, 64'h0000_0000_0000_1000,
      64'h0000_0080_0000_0100, 64'h0000_007F_FFFF_FFF1 };
   localparam logic        V_INTR [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
   localparam logic [5:0]  V_CAUSE [NV] = '{6'd2, 6'd7, 6'd11, 6'd3, 6'd0, 6'd5, 6'd63, 6'd63};
   localparam logic [63:0] V_RD [NV] = '{
      64'h0000_0000_8000_005C, 64'h0000_0000_8000_1001, 64'h0000_0000_8000_2001,
      64'h0000_007F_FFFF_FFFD, 64'h0000_0040_0000_0001, 64'h0000_0000_0000_1000,
      64'h0000_0000_0000_0100, 64'h0000_007F_FFFF_FFF1 };
   localparam logic [63:0] V_PC [NV] = '{
      64'h0000_0000_8000_005C, 64'h0000_0000_8000_101C, 64'h0000_0000_8000_2000,
      64'h0000_0080_0000_0008, 64'h0000_0040_0000_0000, 64'h0000_0000_0000_1000,
      64'h0000_0000_0000_0100, 64'h0000_0080_0000_00EC };
   localparam logic        V_FAULT [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [63:0] v);
      @(negedge clk);
      csr_wr_en = 1'b1; csr_wr_data = v;
      @(negedge clk);
      csr_wr_en = 1'b0;
   endtask

   task automatic do_trap(input logic intr, input logic [5:0] cause);
      trap_valid = 1'b1; trap_is_intr = intr; trap_cause = cause;
      @(negedge clk);
      trap_valid = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [63:0] model;
      logic [63:0] v;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 reset value", csr_rd_data, 64'h0000_0000_8000_0000);
      chk("R1 redirect_valid", {63'd0, redirect_valid}, 64'd0);
      chk("R1 redirect_fault", {63'd0, redirect_fault}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R4 trap from reset vector
      do_trap(1'b1, 6'd9);
      chk("R4 reset-vector redirect", redirect_pc, 64'h0000_0000_8000_0000);
      chk("R9 redirect_valid high", {63'd0, redirect_valid}, 64'd1);

      // Vector table: R2 R3 R5 R7 R8 R9
      for (int i = 0; i < NV; i++) begin
         do_write(V_WR[i]);
         chk("R2/R3 readback", csr_rd_data, V_RD[i]);
         do_trap(V_INTR[i], V_CAUSE[i]);
         chk("R5 redirect_pc", redirect_pc, V_PC[i]);
         chk("R9 redirect_valid high", {63'd0, redirect_valid}, 64'd1);
         chk("R7 redirect_fault", {63'd0, redirect_fault}, {63'd0, V_FAULT[i]});
         chk("R7 fault_cause", {60'd0, fault_cause}, V_FAULT[i] ? 64'd1 : 64'd0);
         if (V_RD[i][1:0] == 2'b00)
            chk("R8 readback equals redirect base", redirect_pc, {V_RD[i][63:2], 2'b00});
         @(negedge clk);
         chk("R9 redirect_valid one cycle", {63'd0, redirect_valid}, 64'd0);
      end

      // R6 write and trap together: old value used, write dropped
      do_write(64'h0000_0000_0000_4000);
      csr_wr_en = 1'b1; csr_wr_data = 64'h0000_0000_0000_8000;
      do_trap(1'b0, 6'd2);
      csr_wr_en = 1'b0;
      chk("R6 trap uses old value", redirect_pc, 64'h0000_0000_0000_4000);
      chk("R6 write discarded", csr_rd_data, 64'h0000_0000_0000_4000);

      // R8 random writes: direct-mode trap base equals readback
      model = csr_rd_data;
      for (int k = 0; k < 24; k++) begin
         v = {$urandom, $urandom};
         model = {25'd0, v[38:2], (v[1:0] < 2'd2) ? v[1:0] : model[1:0]};
         do_write(v);
         chk("R2 random readback", csr_rd_data, model);
         do_trap(1'b0, 6'(k));
         chk("R8 random redirect", redirect_pc, {model[63:2], 2'b00});
         chk("R7 random no fault", {63'd0, redirect_fault}, 64'd0);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule